// File: doc/BRIEF.md
# Three-Read Two-Write Register Bank with Slice Writes

This block is a general-purpose register bank of 64 registers, each 64 bits wide. Three read ports return whole registers. Two write ports can each update only part of the addressed register. Each write port turns its address into a one-hot row select. It also turns its size controls into a bit mask built from four slices: bits 7:0, 15:8, 31:16 and 63:32. The byte slice is always written. The upper three slices are switched on by a 3-bit size vector or by a SIMD flag. A separate chunk-load mode replaces the size mask and writes exactly one 16-bit quarter of the register. A 2-bit index picks the quarter.

The storage array has no reset, and software is expected to fill it before use. The synchronous reset clears only the three registered read outputs. Reads take one clock: an address presented at a rising edge gives its data after that edge. Reads always see the contents from before any write that lands on the same edge.

Top module: `regbank_3r2w`

## Requirements
- R1: Each of the three read ports returns the full 64-bit register at its address one clock after the address is sampled.
- R2: With SIMD and chunk mode low and size code 3'b000, a write changes only bits 7:0 of the addressed register.
- R3: Outside chunk mode, bits 7:0 are always written, bits 15:8 when size[0] or SIMD is set, bits 31:16 when size[1] or SIMD is set, and bits 63:32 when size[2] or SIMD is set. So size code 3'b001 writes 16 bits, 3'b011 writes 32 bits and 3'b111 writes 64 bits.
- R4: With SIMD high and chunk mode low, a write replaces all 64 bits whatever the size code.
- R5: In chunk mode, a write changes only bits 16*q+15 down to 16*q, where q is the 2-bit quarter index. The size code and SIMD flag are ignored.
- R6: A write port whose enable is low changes no register.
- R7: A read sampled on the same edge as a write to the same register returns the value from before that write.
- R8: When both write ports hit one register on one edge, port 1's data goes into every bit both ports enable. Bits enabled by only one port take that port's data.
- R9: Reset forces all three read outputs to zero on the next edge and leaves the array contents unchanged.
- R10: A write changes only the addressed register; every other register keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset of the read outputs |
| rd0_addr | input | 6 | Read port 0 register number |
| rd1_addr | input | 6 | Read port 1 register number |
| rd2_addr | input | 6 | Read port 2 register number |
| rd0_data | output | 64 | Read port 0 data, registered |
| rd1_data | output | 64 | Read port 1 data, registered |
| rd2_data | output | 64 | Read port 2 data, registered |
| wr0_en | input | 1 | Write port 0 enable |
| wr0_addr | input | 6 | Write port 0 register number |
| wr0_data | input | 64 | Write port 0 data |
| wr0_size | input | 3 | Write port 0 size vector |
| wr0_simd | input | 1 | Write port 0 SIMD flag, opens all slices |
| wr0_chunk | input | 1 | Write port 0 chunk-load mode |
| wr0_quarter | input | 2 | Write port 0 quarter index for chunk mode |
| wr1_en | input | 1 | Write port 1 enable |
| wr1_addr | input | 6 | Write port 1 register number |
| wr1_data | input | 64 | Write port 1 data |
| wr1_size | input | 3 | Write port 1 size vector |
| wr1_simd | input | 1 | Write port 1 SIMD flag, opens all slices |
| wr1_chunk | input | 1 | Write port 1 chunk-load mode |
| wr1_quarter | input | 2 | Write port 1 quarter index for chunk mode |

## Verification
A wrong slice mask or a wrong row decode changes the stored word. This stays invisible until some read port addresses that register, and then it shows two cycles after the faulty write edge. The bench therefore keeps a full shadow copy of the bank and compares all three read ports on every cycle. It biases addresses toward a few rows so that corrupted neighbours and port collisions are read back soon. A bad priority between the two write ports shows only on collision edges, so those are also forced on purpose.

// File: rtl/rb_pkg.sv
package rb_pkg;
  // Per-port write control decoded into a slice mask
  typedef struct packed {
    logic [2:0] size;
    logic       simd;
    logic       chunk;
    logic [1:0] quarter;
  } wr_ctl_t;
endpackage

// File: rtl/rb_wr_decode.sv
module rb_wr_decode #(
  parameter int DATA_W = 64,
  parameter int ADDR_W = 6,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic               en,
  input  logic [ADDR_W-1:0]  addr,
  input  rb_pkg::wr_ctl_t    ctl,
  output logic [DEPTH-1:0]   row_sel,
  output logic [DATA_W-1:0]  bit_mask
);
  localparam int A_HI = DATA_W/8 - 1;
  localparam int B_HI = DATA_W/4 - 1;
  localparam int C_HI = DATA_W/2 - 1;
  localparam int QW   = DATA_W/4;

  always_comb begin
    row_sel = '0;
    if (en) row_sel[addr] = 1'b1;
  end

  always_comb begin
    bit_mask = '0;
    if (ctl.chunk) begin
      bit_mask[ctl.quarter*QW +: QW] = '1;
    end else begin
      bit_mask[A_HI:0] = '1;
      if (ctl.size[0] || ctl.simd) bit_mask[B_HI:A_HI+1]   = '1;
      if (ctl.size[1] || ctl.simd) bit_mask[C_HI:B_HI+1]   = '1;
      if (ctl.size[2] || ctl.simd) bit_mask[DATA_W-1:C_HI+1] = '1;
    end
  end
endmodule

// File: rtl/rb_array.sv
module rb_array #(
  parameter int DATA_W = 64,
  parameter int ADDR_W = 6,
  parameter int N_WR   = 2,
  parameter int N_RD   = 3,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic                           clk,
  input  logic [N_WR-1:0][DEPTH-1:0]     row_sel,
  input  logic [N_WR-1:0][DATA_W-1:0]    bit_mask,
  input  logic [N_WR-1:0][DATA_W-1:0]    wdata,
  input  logic [N_RD-1:0][ADDR_W-1:0]    raddr,
  output logic [N_RD-1:0][DATA_W-1:0]    rdata
);
  logic [DATA_W-1:0] row_view [DEPTH];

  for (genvar r = 0; r < DEPTH; r++) begin : g_row
    logic [DATA_W-1:0] row_q;
    logic [DATA_W-1:0] row_d;

    // Higher-numbered ports are merged last and win on shared bits
    always_comb begin
      row_d = row_q;
      for (int p = 0; p < N_WR; p++) begin
        if (row_sel[p][r]) row_d = (row_d & ~bit_mask[p]) | (wdata[p] & bit_mask[p]);
      end
    end

    always_ff @(posedge clk) row_q <= row_d;

    assign row_view[r] = row_q;
  end

  for (genvar i = 0; i < N_RD; i++) begin : g_rd
    assign rdata[i] = row_view[raddr[i]];
  end
endmodule

// File: rtl/rb_rd_port.sv
module rb_rd_port #(
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] raw,
  output logic [DATA_W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= raw;
  end
endmodule

// File: rtl/regbank_3r2w.sv
module regbank_3r2w #(
  parameter int DATA_W = 64,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] rd0_addr,
  input  logic [ADDR_W-1:0] rd1_addr,
  input  logic [ADDR_W-1:0] rd2_addr,
  output logic [DATA_W-1:0] rd0_data,
  output logic [DATA_W-1:0] rd1_data,
  output logic [DATA_W-1:0] rd2_data,
  input  logic              wr0_en,
  input  logic [ADDR_W-1:0] wr0_addr,
  input  logic [DATA_W-1:0] wr0_data,
  input  logic [2:0]        wr0_size,
  input  logic              wr0_simd,
  input  logic              wr0_chunk,
  input  logic [1:0]        wr0_quarter,
  input  logic              wr1_en,
  input  logic [ADDR_W-1:0] wr1_addr,
  input  logic [DATA_W-1:0] wr1_data,
  input  logic [2:0]        wr1_size,
  input  logic              wr1_simd,
  input  logic              wr1_chunk,
  input  logic [1:0]        wr1_quarter
);
  localparam int N_WR  = 2;
  localparam int N_RD  = 3;
  localparam int DEPTH = 1 << ADDR_W;

  logic [N_WR-1:0]                 wr_en;
  logic [N_WR-1:0][ADDR_W-1:0]     wr_addr;
  logic [N_WR-1:0][DATA_W-1:0]     wr_data;
  rb_pkg::wr_ctl_t                 wr_ctl [N_WR];
  logic [N_WR-1:0][DEPTH-1:0]      wr_row;
  logic [N_WR-1:0][DATA_W-1:0]     wr_mask;
  logic [N_RD-1:0][ADDR_W-1:0]     rd_addr;
  logic [N_RD-1:0][DATA_W-1:0]     rd_raw;
  logic [N_RD-1:0][DATA_W-1:0]     rd_q;

  assign wr_en   = {wr1_en, wr0_en};
  assign wr_addr = {wr1_addr, wr0_addr};
  assign wr_data = {wr1_data, wr0_data};
  assign wr_ctl[0] = '{size: wr0_size, simd: wr0_simd, chunk: wr0_chunk, quarter: wr0_quarter};
  assign wr_ctl[1] = '{size: wr1_size, simd: wr1_simd, chunk: wr1_chunk, quarter: wr1_quarter};
  assign rd_addr = {rd2_addr, rd1_addr, rd0_addr};

  for (genvar p = 0; p < N_WR; p++) begin : g_wdec
    rb_wr_decode #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_dec (
      .en       (wr_en[p]),
      .addr     (wr_addr[p]),
      .ctl      (wr_ctl[p]),
      .row_sel  (wr_row[p]),
      .bit_mask (wr_mask[p])
    );
  end

  rb_array #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .N_WR(N_WR), .N_RD(N_RD)) i_array (
    .clk      (clk),
    .row_sel  (wr_row),
    .bit_mask (wr_mask),
    .wdata    (wr_data),
    .raddr    (rd_addr),
    .rdata    (rd_raw)
  );

  for (genvar i = 0; i < N_RD; i++) begin : g_rport
    rb_rd_port #(.DATA_W(DATA_W)) i_rp (
      .clk (clk),
      .rst (rst),
      .raw (rd_raw[i]),
      .q   (rd_q[i])
    );
  end

  assign rd0_data = rd_q[0];
  assign rd1_data = rd_q[1];
  assign rd2_data = rd_q[2];
endmodule

// File: rtl/rb_check.sv
module rb_check #(
  parameter int DATA_W = 64,
  parameter int ADDR_W = 6,
  localparam int DEPTH = 1 << ADDR_W
) (
  input logic                        clk,
  input logic                        rst,
  input logic [ADDR_W-1:0]           rd0_addr,
  input logic [DATA_W-1:0]           rd0_data,
  input logic [DATA_W-1:0]           rd1_data,
  input logic [DATA_W-1:0]           rd2_data,
  input logic                        wr0_en,
  input logic                        wr0_chunk,
  input logic                        wr1_en,
  input logic [ADDR_W-1:0]           wr1_addr,
  input logic [DATA_W-1:0]           wr1_data,
  input logic                        wr1_simd,
  input logic                        wr1_chunk,
  input logic [1:0][DEPTH-1:0]       wr_row,
  input logic [1:0][DATA_W-1:0]      wr_mask
);
  logic [1:0] age;
  always_ff @(posedge clk) begin
    if (rst)           age <= '0;
    else if (age != 2'd3) age <= age + 2'd1;
  end

  a_r9_read_cleared: assert property (@(posedge clk)
    rst |=> (rd0_data == '0 && rd1_data == '0 && rd2_data == '0));

  a_r10_single_row0: assert property (@(posedge clk) disable iff (rst)
    wr0_en |-> $countones(wr_row[0]) == 1);
  a_r10_single_row1: assert property (@(posedge clk) disable iff (rst)
    wr1_en |-> $countones(wr_row[1]) == 1);

  a_r6_idle_port0: assert property (@(posedge clk) disable iff (rst)
    !wr0_en |-> wr_row[0] == '0);
  a_r6_idle_port1: assert property (@(posedge clk) disable iff (rst)
    !wr1_en |-> wr_row[1] == '0);

  a_r5_one_quarter: assert property (@(posedge clk) disable iff (rst)
    (wr0_en && wr0_chunk) |-> $countones(wr_mask[0]) == DATA_W/4);

  a_r3_byte_always: assert property (@(posedge clk) disable iff (rst)
    (wr0_en && !wr0_chunk) |-> &wr_mask[0][DATA_W/8-1:0]);

  // R4 / R1: a full-width write on port 1 is read back two edges later
  a_r4_full_readback: assert property (@(posedge clk) disable iff (rst)
    (age == 2'd3 && $past(wr1_en && wr1_simd && !wr1_chunk, 2)
      && $past(rd0_addr) == $past(wr1_addr, 2))
    |-> rd0_data == $past(wr1_data, 2));
endmodule

bind regbank_3r2w rb_check #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_rb_check (
  .clk       (clk),
  .rst       (rst),
  .rd0_addr  (rd0_addr),
  .rd0_data  (rd0_data),
  .rd1_data  (rd1_data),
  .rd2_data  (rd2_data),
  .wr0_en    (wr0_en),
  .wr0_chunk (wr0_chunk),
  .wr1_en    (wr1_en),
  .wr1_addr  (wr1_addr),
  .wr1_data  (wr1_data),
  .wr1_simd  (wr1_simd),
  .wr1_chunk (wr1_chunk),
  .wr_row    (wr_row),
  .wr_mask   (wr_mask)
);

// File: tb/test_regbank_3r2w.sv
module test_regbank_3r2w;
  localparam int CLK_PERIOD = 10;
  localparam int MAX_CYCLES = 200000;

  logic        clk = 1'b0;
  logic        rst;
  logic [5:0]  ra [3];
  logic [63:0] rd [3];
  logic        we [2];
  logic [5:0]  wa [2];
  logic [63:0] wd [2];
  logic [2:0]  ws [2];
  logic        wsimd [2];
  logic        wchk [2];
  logic [1:0]  wq [2];

  int n_chk = 0;
  int n_err = 0;
  bit finished = 0;

  logic [63:0] model [64];
  bit          known [64];

  always #(CLK_PERIOD/2) clk = ~clk;

  regbank_3r2w i_regbank_3r2w (
    .clk(clk), .rst(rst),
    .rd0_addr(ra[0]), .rd1_addr(ra[1]), .rd2_addr(ra[2]),
    .rd0_data(rd[0]), .rd1_data(rd[1]), .rd2_data(rd[2]),
    .wr0_en(we[0]), .wr0_addr(wa[0]), .wr0_data(wd[0]), .wr0_size(ws[0]),
    .wr0_simd(wsimd[0]), .wr0_chunk(wchk[0]), .wr0_quarter(wq[0]),
    .wr1_en(we[1]), .wr1_addr(wa[1]), .wr1_data(wd[1]), .wr1_size(ws[1]),
    .wr1_simd(wsimd[1]), .wr1_chunk(wchk[1]), .wr1_quarter(wq[1])
  );

  function automatic logic [63:0] ref_mask(input logic [2:0] sz, input logic simd,
                                           input logic chunk, input logic [1:0] q);
    logic [63:0] m;
    if (chunk) return 64'hFFFF << (16 * q);
    m = 64'h0000_0000_0000_00FF;
    if (sz[0] || simd) m |= 64'h0000_0000_0000_FF00;
    if (sz[1] || simd) m |= 64'h0000_0000_FFFF_0000;
    if (sz[2] || simd) m |= 64'hFFFF_FFFF_0000_0000;
    return m;
  endfunction

  task automatic idle_inputs();
    for (int p = 0; p < 2; p++) begin
      we[p] = 0; wa[p] = '0; wd[p] = '0; ws[p] = '0;
      wsimd[p] = 0; wchk[p] = 0; wq[p] = '0;
    end
  endtask

  task automatic check(input string tag, input int port, input logic [63:0] got,
                       input logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s rd%0d got %h expected %h", tag, port, got, exp);
    end
  endtask

  // Inputs are set by the caller at a falling edge; one clock is applied
  task automatic step(input string tag);
    logic [63:0] e [3];
    bit          ev [3];
    for (int i = 0; i < 3; i++) begin
      ev[i] = rst ? 1'b1 : known[ra[i]];
      e[i]  = rst ? 64'h0 : model[ra[i]];
    end
    for (int p = 0; p < 2; p++) begin
      if (we[p]) begin
        logic [63:0] m;
        m = ref_mask(ws[p], wsimd[p], wchk[p], wq[p]);
        model[wa[p]] = (model[wa[p]] & ~m) | (wd[p] & m);
        if (m == '1) known[wa[p]] = 1;
      end
    end
    @(posedge clk);
    @(negedge clk);
    for (int i = 0; i < 3; i++) if (ev[i]) check(tag, i, rd[i], e[i]);
  endtask

  task automatic wr(input int p, input logic [5:0] a, input logic [63:0] d,
                    input logic [2:0] sz, input logic simd, input logic chunk,
                    input logic [1:0] q);
    we[p] = 1; wa[p] = a; wd[p] = d; ws[p] = sz;
    wsimd[p] = simd; wchk[p] = chunk; wq[p] = q;
  endtask

  task automatic read_back(input string tag, input logic [5:0] a);
    idle_inputs();
    ra[0] = a; ra[1] = a; ra[2] = a;
    step(tag);
    step(tag);
  endtask

  initial begin
    void'($urandom(32'd24681));
    for (int r = 0; r < 64; r++) begin model[r] = '0; known[r] = 0; end
    idle_inputs();
    ra[0] = 0; ra[1] = 0; ra[2] = 0;
    rst = 1;
    step("R9");
    rst = 0;

    // fill every register with full-width writes on both ports
    for (int k = 0; k < 32; k++) begin
      wr(0, 6'(2*k),   {$urandom, $urandom}, 3'b111, 0, 0, 2'd0);
      wr(1, 6'(2*k+1), {$urandom, $urandom}, 3'b000, 1, 0, 2'd0);
      step("R4");
    end
    idle_inputs();
    for (int r = 0; r < 64; r++) begin
      ra[0] = 6'(r); ra[1] = 6'(63-r); ra[2] = 6'((r*7) % 64);
      step("R1");
    end

    // directed slice cases
    wr(0, 6'd5, 64'h1111_2222_3333_4455, 3'b000, 0, 0, 2'd0); step("R2");
    read_back("R2", 6'd5);
    wr(0, 6'd5, 64'hAAAA_BBBB_CCCC_DDEE, 3'b001, 0, 0, 2'd0); step("R3");
    read_back("R3", 6'd5);
    wr(1, 6'd6, 64'h0123_4567_89AB_CDEF, 3'b011, 0, 0, 2'd0); step("R3");
    read_back("R3", 6'd6);
    wr(1, 6'd7, 64'hFEDC_BA98_7654_3210, 3'b100, 0, 0, 2'd0); step("R3");
    read_back("R3", 6'd7);
    wr(0, 6'd8, 64'h5A5A_5A5A_5A5A_5A5A, 3'b000, 1, 0, 2'd0); step("R4");
    read_back("R4", 6'd8);
    for (int q = 0; q < 4; q++) begin
      wr(0, 6'd9, {$urandom, $urandom}, 3'b111, 1, 1, 2'(q)); step("R5");
      read_back("R5", 6'd9);
    end
    idle_inputs();
    we[0] = 0; wa[0] = 6'd10; wd[0] = '1; wsimd[0] = 1;
    we[1] = 0; wa[1] = 6'd10; wd[1] = '1; wsimd[1] = 1;
    step("R6");
    read_back("R6", 6'd10);
    // same-edge read and write of one register returns old data
    wr(0, 6'd11, 64'hDEAD_BEEF_0000_1111, 3'b111, 0, 0, 2'd0);
    ra[0] = 6'd11; ra[1] = 6'd11; ra[2] = 6'd11;
    step("R7");
    read_back("R7", 6'd11);
    // collision: port 0 full, port 1 byte
    wr(0, 6'd12, 64'h1111_1111_1111_1111, 3'b111, 0, 0, 2'd0);
    wr(1, 6'd12, 64'h2222_2222_2222_2222, 3'b000, 0, 0, 2'd0);
    step("R8");
    read_back("R8", 6'd12);
    // collision: port 0 chunk quarter 2, port 1 32-bit
    wr(0, 6'd12, 64'h3333_4444_5555_6666, 3'b000, 0, 1, 2'd2);
    wr(1, 6'd12, 64'h7777_8888_9999_AAAA, 3'b011, 0, 0, 2'd0);
    step("R8");
    read_back("R8", 6'd12);
    // reset mid-run keeps contents
    idle_inputs();
    rst = 1; ra[0] = 6'd12; ra[1] = 6'd5; ra[2] = 6'd9;
    step("R9");
    rst = 0;
    step("R9");
    step("R9");

    // constrained random traffic, addresses biased to few rows
    for (int n = 0; n < 3000; n++) begin
      for (int p = 0; p < 2; p++) begin
        logic [2:0] sz;
        int pick;
        pick = $urandom % 5;
        sz = (pick == 0) ? 3'b000 : (pick == 1) ? 3'b001 :
             (pick == 2) ? 3'b011 : (pick == 3) ? 3'b111 : 3'($urandom);
        we[p] = ($urandom % 4) != 0;
        wa[p] = ($urandom % 2) ? 6'($urandom % 8) : 6'($urandom);
        wd[p] = {$urandom, $urandom};
        ws[p] = sz;
        wsimd[p] = ($urandom % 4) == 0;
        wchk[p] = ($urandom % 4) == 0;
        wq[p] = 2'($urandom);
      end
      for (int i = 0; i < 3; i++)
        ra[i] = ($urandom % 2) ? 6'($urandom % 8) : 6'($urandom);
      step("R10");
    end
    idle_inputs();
    for (int r = 0; r < 64; r++) begin
      ra[0] = 6'(r); ra[1] = 6'(r); ra[2] = 6'(r);
      step("R10");
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * MAX_CYCLES);
    if (!finished) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end
endmodule